// File: doc/BRIEF.md
# Work-Packet Counter and Status Controller

This block keeps track of how many work packets software has queued for a descriptor-driven processing engine, and it records what happened as each packet finishes. Software raises the pending count through an increment port. The engine reports each finished packet with a one-cycle strobe that carries the packet's control bits: an 8-bit tag, a chain bit, a decrement bit and an interrupt-on-done bit. The datapath reports faults on five separate error strobes.

The block compares the chain bit with the pending count. A packet that chains while no work is left makes the engine wait for new work. A packet that ends the chain while work is still pending is a chain fault. Every event sets a sticky flag that software clears by writing one. A summary request flag, gated by an enable input, drives the interrupt pin. A small decoder tells the engine whether to fetch the next descriptor, wait or stop.

Top module: `pktstat_ctrl`

## Requirements
- R1: A cycle with `inc_wr` high adds `inc_val` to `count`, and the result saturates at the all-ones value (255 with default widths).
- R2: A cycle with `pkt_done` and `pkt_dec` high lowers `count` by one. If an increment lands in the same cycle, the result is count + increment − 1, clamped to the range 0 to 255. A decrement at zero leaves `count` at 0.
- R3: The count-zero flag (bit 7) sets when a packet with its decrement bit set finishes and the updated count is zero.
- R4: The chain-wait flag (bit 8) sets when a finished packet has chain = 1 and the updated count is zero.
- R5: The chain-fault flag (bit 0) sets when a finished packet has chain = 0 and the updated count is nonzero.
- R6: The packet-done flag (bit 6) sets on completion only when that packet's `pkt_irq` bit is 1.
- R7: The error strobes set sticky flags at these positions: hash check at bit 1, destination buffer at bit 2, source buffer at bit 3, header access at bit 4, mode setup at bit 5. `flags` is 10 bits wide; bit 9 is the request flag.
- R8: The request flag (bit 9) sets on any error strobe, on a packet-done event and on a count-zero event. A chain-wait event sets it only while `test_irq` is 1.
- R9: `w1c_wr` clears every flag whose bit is 1 in `w1c_mask`. A flag that is set and cleared in the same cycle stays set.
- R10: `tag` holds the tag of the most recently finished packet.
- R11: `irq` is high exactly when `irq_en` is 1 and the request flag is set.
- R12: `next_act` is 0 (stop) while any fault flag (bits 0 to 5) is set. Otherwise it is 1 (fetch) while `count` is nonzero, 2 (wait) while the chain-wait flag is set, and 0 in all other cases.
- R13: `soft_rst` on a clock edge, or `rst_n` low at any time, clears `count`, all flags and `tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of all state |
| irq_en | input | 1 | Interrupt enable |
| test_irq | input | 1 | Chain-wait events also raise the request flag |
| inc_wr | input | 1 | Increment write strobe |
| inc_val | input | CNT_W | Amount to add to the count |
| pkt_done | input | 1 | Packet finished strobe |
| pkt_tag | input | TAG_W | Tag of the finished packet |
| pkt_chain | input | 1 | Chain bit of the finished packet |
| pkt_dec | input | 1 | Decrement bit of the finished packet |
| pkt_irq | input | 1 | Interrupt-on-done bit of the finished packet |
| err_mode | input | 1 | Mode setup error strobe |
| err_hdr | input | 1 | Packet header access error strobe |
| err_src | input | 1 | Source buffer error strobe |
| err_dst | input | 1 | Destination buffer error strobe |
| err_hash | input | 1 | Hash check error strobe |
| w1c_wr | input | 1 | Write-one-to-clear strobe |
| w1c_mask | input | 10 | Flags to clear |
| count | output | CNT_W | Pending packet count |
| flags | output | 10 | Sticky status flags |
| tag | output | TAG_W | Latched tag of the last finished packet |
| irq | output | 1 | Gated interrupt request |
| next_act | output | 2 | Engine action: 0 stop, 1 fetch, 2 wait |

## Verification
The bench builds the block with its default 8-bit count and 8-bit tag. These widths let a few increment writes reach the 255 ceiling, so saturation is exercised, including an increment and a decrement that land on the ceiling in the same cycle. The small range also makes it cheap to drain the count to zero. Reaching zero is where the chain cross-check, the count-zero flag and the wait decision all meet, and the bench also drives a decrement at zero there.

// File: rtl/pktstat_pkg.sv
package pktstat_pkg;

  localparam int FLG_N     = 10;
  localparam int FLG_CHERR = 0;
  localparam int FLG_HASH  = 1;
  localparam int FLG_DST   = 2;
  localparam int FLG_SRC   = 3;
  localparam int FLG_HDR   = 4;
  localparam int FLG_MODE  = 5;
  localparam int FLG_DONE  = 6;
  localparam int FLG_ZERO  = 7;
  localparam int FLG_WAIT  = 8;
  localparam int FLG_REQ   = 9;

  // datapath error strobes occupy flag bits ERR_LO .. ERR_LO+ERR_N-1
  localparam int ERR_N  = 5;
  localparam int ERR_LO = FLG_HASH;
  // fault flags that stop the engine: chain fault plus all datapath errors
  localparam int FAULT_HI = ERR_LO + ERR_N - 1;

  typedef enum logic [1:0] {
    ACT_STOP  = 2'd0,
    ACT_FETCH = 2'd1,
    ACT_WAIT  = 2'd2
  } act_e;

endpackage

// File: rtl/pktstat_counter.sv
// Saturating pending-packet counter with simultaneous increment and decrement.
module pktstat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             inc_wr,
  input  logic [CNT_W-1:0] inc_val,
  input  logic             dec_en,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_nxt
);

  localparam int EXT_W = CNT_W + 2;
  localparam logic [EXT_W-1:0] MAX_EXT = {2'b00, {CNT_W{1'b1}}};

  logic [EXT_W-1:0] sum_ext;
  logic [EXT_W-1:0] dec_ext;
  logic             cnt_ce;

  always_comb begin
    sum_ext = {2'b00, count_q};
    if (inc_wr) begin
      sum_ext = sum_ext + {2'b00, inc_val};
    end
    dec_ext = sum_ext;
    if (dec_en && (sum_ext != '0)) begin
      dec_ext = sum_ext - 1'b1;
    end
    if (dec_ext > MAX_EXT) begin
      dec_ext = MAX_EXT;
    end
    if (soft_rst) begin
      count_nxt = '0;
    end else begin
      count_nxt = dec_ext[CNT_W-1:0];
    end
    cnt_ce = soft_rst | inc_wr | dec_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_ce) begin
      count_q <= count_nxt;
    end
  end

endmodule

// File: rtl/pktstat_flags.sv
// Sticky status flags, request summary and tag latch.
module pktstat_flags
  import pktstat_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 test_irq,
  input  logic                 pkt_done,
  input  logic [TAG_W-1:0]     pkt_tag,
  input  logic                 pkt_chain,
  input  logic                 pkt_dec,
  input  logic                 pkt_irq,
  input  logic [ERR_N-1:0]     err_vec,
  input  logic                 nxt_zero,
  input  logic                 w1c_wr,
  input  logic [FLG_N-1:0]     w1c_mask,
  output logic [FLG_N-1:0]     flags_q,
  output logic [TAG_W-1:0]     tag_q
);

  logic [FLG_N-1:0] set_vec;
  logic [FLG_N-1:0] clr_vec;
  logic [TAG_W-1:0] tag_nxt;
  logic             tag_ce;

  // event detection
  always_comb begin
    set_vec = '0;
    set_vec[FLG_CHERR] = pkt_done & ~pkt_chain & ~nxt_zero;
    set_vec[ERR_LO +: ERR_N] = err_vec;
    set_vec[FLG_DONE]  = pkt_done & pkt_irq;
    set_vec[FLG_ZERO]  = pkt_done & pkt_dec & nxt_zero;
    set_vec[FLG_WAIT]  = pkt_done & pkt_chain & nxt_zero;
    set_vec[FLG_REQ]   = (|set_vec[FAULT_HI:0]) | set_vec[FLG_DONE]
                       | set_vec[FLG_ZERO] | (set_vec[FLG_WAIT] & test_irq);
    clr_vec = w1c_wr ? w1c_mask : '0;
  end

  // one sticky cell per flag; a set event wins over a clear
  for (genvar g = 0; g < FLG_N; g++) begin : g_flag
    logic bit_nxt;
    logic bit_ce;

    always_comb begin
      bit_ce  = soft_rst | set_vec[g] | clr_vec[g];
      bit_nxt = soft_rst ? 1'b0 : (set_vec[g] | (flags_q[g] & ~clr_vec[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[g] <= 1'b0;
      end else if (bit_ce) begin
        flags_q[g] <= bit_nxt;
      end
    end
  end

  always_comb begin
    tag_ce  = soft_rst | pkt_done;
    tag_nxt = soft_rst ? '0 : pkt_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (tag_ce) begin
      tag_q <= tag_nxt;
    end
  end

endmodule

// File: rtl/pktstat_action.sv
// Decides what the engine does next from the count and the flags.
module pktstat_action
  import pktstat_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] count_q,
  input  logic [FLG_N-1:0] flags_q,
  output act_e             act
);

  logic fault;

  always_comb begin
    fault = |flags_q[FAULT_HI:0];
    if (fault) begin
      act = ACT_STOP;
    end else if (count_q != '0) begin
      act = ACT_FETCH;
    end else if (flags_q[FLG_WAIT]) begin
      act = ACT_WAIT;
    end else begin
      act = ACT_STOP;
    end
  end

endmodule

// File: rtl/pktstat_ctrl.sv
module pktstat_ctrl
  import pktstat_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             irq_en,
  input  logic             test_irq,
  input  logic             inc_wr,
  input  logic [CNT_W-1:0] inc_val,
  input  logic             pkt_done,
  input  logic [TAG_W-1:0] pkt_tag,
  input  logic             pkt_chain,
  input  logic             pkt_dec,
  input  logic             pkt_irq,
  input  logic             err_mode,
  input  logic             err_hdr,
  input  logic             err_src,
  input  logic             err_dst,
  input  logic             err_hash,
  input  logic             w1c_wr,
  input  logic [9:0]       w1c_mask,
  output logic [CNT_W-1:0] count,
  output logic [9:0]       flags,
  output logic [TAG_W-1:0] tag,
  output logic             irq,
  output logic [1:0]       next_act
);

  logic [CNT_W-1:0] count_nxt;
  logic [ERR_N-1:0] err_vec;
  logic             dec_en;
  logic             nxt_zero;
  act_e             act;

  always_comb begin
    dec_en   = pkt_done & pkt_dec;
    nxt_zero = (count_nxt == '0);
    err_vec  = {err_mode, err_hdr, err_src, err_dst, err_hash};
  end

  pktstat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .inc_wr    (inc_wr),
    .inc_val   (inc_val),
    .dec_en    (dec_en),
    .count_q   (count),
    .count_nxt (count_nxt)
  );

  pktstat_flags #(.TAG_W(TAG_W)) u_flg (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .test_irq  (test_irq),
    .pkt_done  (pkt_done),
    .pkt_tag   (pkt_tag),
    .pkt_chain (pkt_chain),
    .pkt_dec   (pkt_dec),
    .pkt_irq   (pkt_irq),
    .err_vec   (err_vec),
    .nxt_zero  (nxt_zero),
    .w1c_wr    (w1c_wr),
    .w1c_mask  (w1c_mask),
    .flags_q   (flags),
    .tag_q     (tag)
  );

  pktstat_action #(.CNT_W(CNT_W)) u_act (
    .count_q (count),
    .flags_q (flags),
    .act     (act)
  );

  always_comb begin
    irq      = irq_en & flags[FLG_REQ];
    next_act = act;
  end

endmodule

// File: rtl/pktstat_chk.sv
module pktstat_chk #(
  parameter int CNT_W = 8,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             irq_en,
  input logic             inc_wr,
  input logic             pkt_done,
  input logic             pkt_dec,
  input logic             pkt_irq,
  input logic             err_mode,
  input logic             err_hdr,
  input logic             err_src,
  input logic             err_dst,
  input logic             err_hash,
  input logic             w1c_wr,
  input logic [CNT_W-1:0] count,
  input logic [9:0]       flags,
  input logic [TAG_W-1:0] tag,
  input logic             irq
);

  AST_INC_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_wr && !(pkt_done && pkt_dec) && !soft_rst) |=> (count >= $past(count))); // R1

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_dec && !inc_wr && !soft_rst && count != '0)
      |=> (count == $past(count) - 1'b1)); // R2

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_irq && !soft_rst) |=> flags[6]); // R6

  AST_REQ_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_mode || err_hdr || err_src || err_dst || err_hash) && !soft_rst) |=> flags[9]); // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !w1c_wr) |=> (($past(flags) & ~flags) == '0)); // R9

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && flags[9])); // R11

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (count == '0 && flags == '0 && tag == '0)); // R13

endmodule

bind pktstat_ctrl pktstat_chk #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (soft_rst),
  .irq_en   (irq_en),
  .inc_wr   (inc_wr),
  .pkt_done (pkt_done),
  .pkt_dec  (pkt_dec),
  .pkt_irq  (pkt_irq),
  .err_mode (err_mode),
  .err_hdr  (err_hdr),
  .err_src  (err_src),
  .err_dst  (err_dst),
  .err_hash (err_hash),
  .w1c_wr   (w1c_wr),
  .count    (count),
  .flags    (flags),
  .tag      (tag),
  .irq      (irq)
);

// File: tb/sim_pktstat_ctrl.sv
module sim_pktstat_ctrl;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       iw;
    logic [7:0] iv;
    logic       dec;
    logic [7:0] exp;
  } vec_t;

  // count sequence from zero: increment, decrement, both, saturation
  localparam vec_t VEC [7] = '{
    '{1'b1, 8'd5,   1'b0, 8'd5},
    '{1'b0, 8'd0,   1'b1, 8'd4},
    '{1'b1, 8'd3,   1'b1, 8'd6},
    '{1'b1, 8'd250, 1'b0, 8'd255},
    '{1'b1, 8'd1,   1'b0, 8'd255},
    '{1'b1, 8'd1,   1'b1, 8'd255},
    '{1'b0, 8'd0,   1'b1, 8'd254}
  };

  logic       clk = 1'b0;
  logic       rst_n, soft_rst, irq_en, test_irq, inc_wr;
  logic [7:0] inc_val, pkt_tag;
  logic       pkt_done, pkt_chain, pkt_dec, pkt_irq;
  logic [4:0] errs;
  logic       w1c_wr;
  logic [9:0] w1c_mask;
  logic [7:0] count, tag;
  logic [9:0] flags;
  logic       irq;
  logic [1:0] next_act;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktstat_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .irq_en(irq_en), .test_irq(test_irq),
    .inc_wr(inc_wr), .inc_val(inc_val), .pkt_done(pkt_done), .pkt_tag(pkt_tag),
    .pkt_chain(pkt_chain), .pkt_dec(pkt_dec), .pkt_irq(pkt_irq),
    .err_mode(errs[4]), .err_hdr(errs[3]), .err_src(errs[2]), .err_dst(errs[1]),
    .err_hash(errs[0]), .w1c_wr(w1c_wr), .w1c_mask(w1c_mask),
    .count(count), .flags(flags), .tag(tag), .irq(irq), .next_act(next_act)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    soft_rst = 0; inc_wr = 0; inc_val = 0; pkt_done = 0; pkt_tag = 0;
    pkt_chain = 0; pkt_dec = 0; pkt_irq = 0; errs = 0; w1c_wr = 0; w1c_mask = 0;
  endtask

  // one clock edge, then release strobes away from the edge
  task automatic cyc();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic pkt(input logic ch, input logic dc, input logic pi, input logic [7:0] tg);
    pkt_done = 1; pkt_chain = ch; pkt_dec = dc; pkt_irq = pi; pkt_tag = tg;
    cyc();
  endtask

  task automatic clear_all();
    w1c_wr = 1; w1c_mask = 10'h3FF;
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; irq_en = 0; test_irq = 0;
    idle();
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R13 reset count", count, 0);
    chk("R13 reset flags", flags, 0);
    chk("R13 reset tag", tag, 0);
    chk("R11 reset irq", irq, 0);
    chk("R12 reset act stop", next_act, 0);

    // table walk: R1 / R2
    foreach (VEC[i]) begin
      inc_wr = VEC[i].iw; inc_val = VEC[i].iv;
      if (VEC[i].dec) begin
        pkt_done = 1; pkt_chain = 1; pkt_dec = 1; pkt_tag = 8'(i);
      end
      cyc();
      chk(VEC[i].dec ? "R2 count step" : "R1 count step", count, VEC[i].exp);
    end
    chk("R5 no fault while chaining", flags, 0);
    chk("R12 fetch while pending", next_act, 1);

    soft_rst = 1; cyc();
    chk("R13 soft reset count", count, 0);
    chk("R13 soft reset tag", tag, 0);

    // drain to zero: R3, R6, R8, R10, R11
    inc_wr = 1; inc_val = 2; cyc();
    pkt(1'b1, 1'b1, 1'b0, 8'h11);
    chk("R2 count 1", count, 1);
    chk("R6 no done flag without pkt_irq", flags, 0);
    pkt(1'b0, 1'b1, 1'b1, 8'h22);
    chk("R3 count zero flags", flags, 10'h2C0);
    chk("R10 tag latched", tag, 8'h22);
    chk("R12 stop at zero", next_act, 0);
    irq_en = 1; #1;
    chk("R11 irq enabled", irq, 1);
    irq_en = 0; #1;
    chk("R11 irq gated", irq, 0);

    // R9 partial clear
    w1c_wr = 1; w1c_mask = 10'h040; cyc();
    chk("R9 partial clear", flags, 10'h280);
    clear_all();
    chk("R9 full clear", flags, 0);

    // R4 chain wait, test bit off then on
    pkt(1'b1, 1'b0, 1'b0, 8'h33);
    chk("R4 chain wait no request", flags, 10'h100);
    chk("R12 wait action", next_act, 2);
    clear_all();
    test_irq = 1;
    pkt(1'b1, 1'b0, 1'b0, 8'h34);
    chk("R8 test bit raises request", flags, 10'h300);
    test_irq = 0;
    clear_all();

    // R5 chain fault
    inc_wr = 1; inc_val = 3; cyc();
    chk("R12 fetch after increment", next_act, 1);
    pkt(1'b0, 1'b1, 1'b0, 8'h44);
    chk("R5 chain fault count", count, 2);
    chk("R5 chain fault flags", flags, 10'h201);
    chk("R12 stop on fault", next_act, 0);
    clear_all();

    // R7 each error strobe
    for (int k = 0; k < 5; k++) begin
      errs = 5'(1 << k); cyc();
      chk("R7 error flag position", flags, 10'h200 | 10'(2 << k));
      clear_all();
    end

    // R9 set wins over clear
    errs = 5'b00001; w1c_wr = 1; w1c_mask = 10'h3FF; cyc();
    chk("R9 set wins", flags, 10'h202);
    clear_all();

    // R2 decrement at zero
    pkt(1'b1, 1'b1, 1'b0, 8'h55);
    pkt(1'b1, 1'b1, 1'b0, 8'h56);
    chk("R4 zero and wait flags", flags, 10'h380);
    pkt(1'b1, 1'b1, 1'b0, 8'h57);
    chk("R2 decrement at zero", count, 0);
    clear_all();

    // R13 async reset
    inc_wr = 1; inc_val = 7; errs = 5'b10000; cyc();
    rst_n = 0; #2;
    chk("R13 async count", count, 0);
    chk("R13 async flags", flags, 0);
    chk("R13 async tag", tag, 0);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule